// File: doc/BRIEF.md
# Two-Stage Pipelined Four-Operation Processor

This block is a small 32-bit processor core built as two pipeline stages. The front stage fetches the word at the program counter, splits it into fields, reads the source registers and packs the operand values into a decoded template. The back stage takes that template from a single pipeline register and performs it: it adds two values, loads from or stores to data memory, or tests a value against zero and redirects the program counter. The pipeline register holds either one template or an empty slot (a bubble).

The core has 32 general registers of 32 bits, an instruction port and a data port. Both memories attached to it answer a read combinationally in the same cycle and commit a write at the clock edge. A build parameter picks one of two hazard policies. In the forwarding variant, the result being written back this cycle is steered straight into decode. In the stall-only variant, decode waits one cycle and sends a bubble whenever it needs a register that the back stage is about to write. Both variants execute any program to the same final state; the forwarding one needs fewer cycles on dependent code.

Top module: `core2_pipe_cpu`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the instruction address is 0, the pipeline register is empty and the data write strobe is low.
- R2: With no stall and no taken branch, the instruction address rises by exactly 1 at each clock edge.
- R3: An instruction word keeps its opcode in bits 31:30 and register fields in bits 29:25 (field A), 24:20 (field B) and 19:15 (field C); the low 15 bits are ignored. Opcode 00 is add: register A receives register B plus register C.
- R4: Opcode 10 is load: register A receives the data memory word addressed by register B.
- R5: Opcode 11 is store: while it occupies the back stage, the write strobe is high for one cycle, the data address is register B and the write data is register A.
- R6: Opcode 01 is branch-if-zero on register A: when register A is zero, the next instruction address is the value of register B, and the instruction fetched in that cycle is discarded without effect.
- R7: A branch-if-zero whose register A is non-zero lets the program continue at the next sequential address.
- R8: With forwarding selected, an instruction that reads a register written by the add or load in the back stage proceeds without a stall and receives the new value.
- R9: With forwarding off, such an instruction is held: the instruction address stays put for one cycle and a bubble enters the pipeline register.
- R10: Hazard comparisons use only register fields that an instruction reads (B for load; A and B for store and branch; B and C for add); an unused field that matches a pending destination causes no stall.
- R11: Both variants leave data memory in the state a one-instruction-per-step reference produces, and the forwarding variant reaches the end of a dependent program in fewer cycles than the stall-only variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction word address (program counter) |
| imem_rdata | input | 32 | Instruction word returned in the same cycle |
| dmem_addr | output | 32 | Data word address for load or store |
| dmem_wdata | output | 32 | Data to be written by a store |
| dmem_we | output | 1 | Data write strobe, committed at the clock edge |
| dmem_rdata | input | 32 | Data word returned in the same cycle |

## Verification
The two functions that meet in one cycle are the register write-back of the back stage and the operand read of the front stage for the same register: the register file still returns the old word, so the forwarded value (or, without forwarding, a stall) must win. The test program chains each add and load directly behind the instruction that produces its source, including a store whose value and address both come from the register just loaded, and a branch whose target register was loaded one slot earlier. A second collision is a taken branch in the back stage while a store sits in fetch; the final memory word at that store's address shows whether the squash held. Both variants are judged against a reference model in the bench, by exact cycle counts to the end of the program, and by cycle-accurate port checks at chosen points.

// File: rtl/core2_pkg.sv
package core2_pkg;

    localparam int XLEN  = 32;
    localparam int NREGS = 32;
    localparam int RAW   = $clog2(NREGS);
    localparam int OPW   = 2;
    localparam int PADW  = XLEN - OPW - 3 * RAW;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RAW-1:0]  ridx_t;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 2'b00,
        OP_BZ  = 2'b01,
        OP_LD  = 2'b10,
        OP_ST  = 2'b11
    } op_e;

    typedef struct packed {
        op_e   op;
        ridx_t fa;
        ridx_t fb;
        ridx_t fc;
    } fields_t;

    // Decoded template: a/b carry operand values.
    // add: a+b | branch: a=cond, b=target | load: a=addr | store: a=value, b=addr
    typedef struct packed {
        logic  valid;
        op_e   op;
        ridx_t dst;
        word_t a;
        word_t b;
    } tmpl_t;

    function automatic fields_t split_word(word_t w);
        fields_t f;
        f.op = op_e'(w[XLEN-1 -: OPW]);
        f.fa = w[XLEN-OPW-1 -: RAW];
        f.fb = w[XLEN-OPW-RAW-1 -: RAW];
        f.fc = w[XLEN-OPW-2*RAW-1 -: RAW];
        return f;
    endfunction

    function automatic ridx_t first_src(fields_t f);
        return (f.op == OP_ADD || f.op == OP_LD) ? f.fb : f.fa;
    endfunction

    function automatic ridx_t second_src(fields_t f);
        return (f.op == OP_ADD) ? f.fc : f.fb;
    endfunction

    function automatic logic needs_second(op_e op);
        return op != OP_LD;
    endfunction

    function automatic logic writes_reg(op_e op);
        return op == OP_ADD || op == OP_LD;
    endfunction

endpackage

// File: rtl/core2_regfile.sv
module core2_regfile
    import core2_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ridx_t rd_a_idx,
    input  ridx_t rd_b_idx,
    output word_t rd_a,
    output word_t rd_b,
    input  logic  wr_en,
    input  ridx_t wr_idx,
    input  word_t wr_data
);

    word_t regs [NREGS];

    // Reads are combinational from the array: a same-cycle write is not seen.
    assign rd_a = regs[rd_a_idx];
    assign rd_b = regs[rd_b_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) begin
                regs[i] <= '0;
            end
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/core2_decode.sv
module core2_decode
    import core2_pkg::*;
#(
    parameter bit FWD_EN = 1'b1
) (
    input  word_t instr,
    input  logic  wb_en,
    input  ridx_t wb_idx,
    input  word_t wb_data,
    output ridx_t rd_a_idx,
    output ridx_t rd_b_idx,
    input  word_t rd_a,
    input  word_t rd_b,
    output tmpl_t next_t,
    output logic  stall
);

    fields_t f;
    logic    hit_a;
    logic    hit_b;
    word_t   val_a;
    word_t   val_b;

    assign f        = split_word(instr);
    assign rd_a_idx = first_src(f);
    assign rd_b_idx = second_src(f);

    // Only fields the instruction reads take part in the comparison.
    assign hit_a = wb_en && (wb_idx == rd_a_idx);
    assign hit_b = wb_en && needs_second(f.op) && (wb_idx == rd_b_idx);

    generate
        if (FWD_EN) begin : g_forward
            assign val_a = hit_a ? wb_data : rd_a;
            assign val_b = hit_b ? wb_data : rd_b;
            assign stall = 1'b0;
        end else begin : g_interlock
            assign val_a = rd_a;
            assign val_b = rd_b;
            assign stall = hit_a || hit_b;
        end
    endgenerate

    always_comb begin
        next_t       = '0;
        next_t.valid = 1'b1;
        next_t.op    = f.op;
        next_t.dst   = f.fa;
        next_t.a     = val_a;
        next_t.b     = needs_second(f.op) ? val_b : '0;
    end

endmodule

// File: rtl/core2_execute.sv
module core2_execute
    import core2_pkg::*;
(
    input  tmpl_t cur,
    input  word_t dmem_rdata,
    output word_t dmem_addr,
    output word_t dmem_wdata,
    output logic  dmem_we,
    output logic  wb_en,
    output ridx_t wb_idx,
    output word_t wb_data,
    output logic  redirect,
    output word_t target
);

    assign dmem_addr  = (cur.op == OP_ST) ? cur.b : cur.a;
    assign dmem_wdata = cur.a;
    assign wb_idx     = cur.dst;
    assign target     = cur.b;

    always_comb begin
        dmem_we  = 1'b0;
        wb_en    = 1'b0;
        wb_data  = '0;
        redirect = 1'b0;
        if (cur.valid) begin
            unique case (cur.op)
                OP_ADD: begin
                    wb_en   = 1'b1;
                    wb_data = cur.a + cur.b;
                end
                OP_LD: begin
                    wb_en   = 1'b1;
                    wb_data = dmem_rdata;
                end
                OP_ST: begin
                    dmem_we = 1'b1;
                end
                OP_BZ: begin
                    redirect = (cur.a == '0);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/core2_pipe_cpu.sv
module core2_pipe_cpu
    import core2_pkg::*;
#(
    parameter bit FWD_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);

    word_t pc_q;
    tmpl_t pipe_q;
    tmpl_t dec_t;
    logic  stall_w;
    logic  redirect_w;
    word_t target_w;
    logic  wb_en;
    ridx_t wb_idx;
    word_t wb_data;
    ridx_t rd_a_idx;
    ridx_t rd_b_idx;
    word_t rd_a;
    word_t rd_b;

    assign imem_addr = pc_q;

    core2_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (rd_a_idx),
        .rd_b_idx (rd_b_idx),
        .rd_a     (rd_a),
        .rd_b     (rd_b),
        .wr_en    (wb_en),
        .wr_idx   (wb_idx),
        .wr_data  (wb_data)
    );

    core2_decode #(.FWD_EN(FWD_EN)) u_dec (
        .instr    (imem_rdata),
        .wb_en    (wb_en),
        .wb_idx   (wb_idx),
        .wb_data  (wb_data),
        .rd_a_idx (rd_a_idx),
        .rd_b_idx (rd_b_idx),
        .rd_a     (rd_a),
        .rd_b     (rd_b),
        .next_t   (dec_t),
        .stall    (stall_w)
    );

    core2_execute u_exe (
        .cur        (pipe_q),
        .dmem_rdata (dmem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .wb_en      (wb_en),
        .wb_idx     (wb_idx),
        .wb_data    (wb_data),
        .redirect   (redirect_w),
        .target     (target_w)
    );

    // Taken branch has priority: it squashes whatever is being decoded.
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            pipe_q <= '0;
        end else if (redirect_w) begin
            pc_q   <= target_w;
            pipe_q <= '0;
        end else if (stall_w) begin
            pipe_q <= '0;
        end else begin
            pc_q   <= pc_q + word_t'(1);
            pipe_q <= dec_t;
        end
    end

endmodule

// File: rtl/core2_checker.sv
module core2_checker
    import core2_pkg::*;
#(
    parameter bit FWD_EN = 1'b1
) (
    input logic  clk,
    input logic  rst,
    input word_t pc,
    input logic  pipe_valid,
    input op_e   pipe_op,
    input logic  stall,
    input logic  redirect,
    input word_t target,
    input logic  dmem_we
);

    logic rst_seen;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
    end

    always @(negedge clk) begin
        if (rst_seen === 1'b1) begin
            assert_reset_state_R1: assert (pc == '0 && !pipe_valid && !dmem_we);
        end
    end

    assert_seq_pc_R2: assert property (@(posedge clk) disable iff (rst)
        (!redirect && !stall) |=> (pc == $past(pc) + word_t'(1)));

    assert_store_slot_R5: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (pipe_valid && pipe_op == OP_ST));

    assert_branch_squash_R6: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (!pipe_valid && pc == $past(target)));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
        stall |=> (!pipe_valid && $stable(pc)));

    generate
        if (FWD_EN) begin : g_fwd_chk
            assert_no_stall_R8: assert property (@(posedge clk) disable iff (rst)
                !stall);
        end
    endgenerate

endmodule

bind core2_pipe_cpu core2_checker #(.FWD_EN(FWD_EN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc         (pc_q),
    .pipe_valid (pipe_q.valid),
    .pipe_op    (pipe_q.op),
    .stall      (stall_w),
    .redirect   (redirect_w),
    .target     (target_w),
    .dmem_we    (dmem_we)
);

// File: tb/tb_core2_pipe_cpu.sv
`timescale 1ns/1ps
module tb_core2_pipe_cpu;
    import core2_pkg::*;

    localparam int DMEM_N  = 64;
    localparam int PROG_N  = 20;
    localparam int HALT_PC = 19;

    function automatic word_t enc(op_e op, int a, int b, int c);
        return {op, ridx_t'(a), ridx_t'(b), ridx_t'(c), {PADW{1'b0}}};
    endfunction

    // Program table (stimulus). Field C of entries 4 and 7 is unused but
    // names the register the previous instruction writes (R10).
    localparam word_t PROG [PROG_N] = '{
        enc(OP_LD , 1, 0, 0),   // 0  r1 = m[r0]=5
        enc(OP_ADD, 2, 1, 1),   // 1  r2 = 10
        enc(OP_ADD, 3, 2, 1),   // 2  r3 = 15
        enc(OP_ADD, 4, 3, 3),   // 3  r4 = 30
        enc(OP_LD , 6, 1, 4),   // 4  r6 = m[5]=40
        enc(OP_ST , 4, 6, 0),   // 5  m[40] = 30
        enc(OP_LD , 7, 6, 0),   // 6  r7 = 30
        enc(OP_LD , 8, 2, 7),   // 7  r8 = m[10]=12
        enc(OP_BZ , 1, 8, 0),   // 8  not taken
        enc(OP_BZ , 0, 8, 0),   // 9  taken -> 12
        enc(OP_ST , 1, 6, 0),   // 10 squashed
        enc(OP_ST , 1, 6, 0),   // 11 skipped
        enc(OP_ADD, 9, 7, 4),   // 12 r9 = 60
        enc(OP_ADD, 10, 6, 1),  // 13 r10 = 45
        enc(OP_ST , 9, 10, 0),  // 14 m[45] = 60
        enc(OP_ST , 2, 3, 0),   // 15 m[15] = 10
        enc(OP_LD , 11, 3, 0),  // 16 r11 = 10
        enc(OP_ST , 11, 11, 0), // 17 m[10] = 10
        enc(OP_LD , 12, 4, 0),  // 18 r12 = m[30]=19
        enc(OP_BZ , 0, 12, 0)   // 19 halt loop
    };

    // Expected-result table: address and final word.
    localparam int EXP_N = 4;
    localparam int EXP_ADDR [EXP_N] = '{40, 45, 15, 10};
    localparam int EXP_VAL  [EXP_N] = '{30, 60, 10, 10};
    string exp_tag [EXP_N] = '{"R6 squashed store", "R3 R4 add of loaded words",
                               "R5 store", "R8 forwarded store operands"};

    function automatic word_t init_val(int i);
        case (i)
            0:       return 32'd5;
            5:       return 32'd40;
            10:      return 32'd12;
            30:      return 32'd19;
            default: return 32'd0;
        endcase
    endfunction

    function automatic word_t fetch(word_t a);
        return (a < PROG_N) ? PROG[a[4:0]] : '0;
    endfunction

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  preload = 1'b1;
    always #2.5 clk = ~clk;

    word_t ia_f, ir_f, da_f, dw_f, dr_f;
    word_t ia_s, ir_s, da_s, dw_s, dr_s;
    logic  we_f, we_s;
    word_t mem_f [DMEM_N];
    word_t mem_s [DMEM_N];
    word_t ref_mem [DMEM_N];

    assign ir_f = fetch(ia_f);
    assign ir_s = fetch(ia_s);
    assign dr_f = mem_f[da_f[5:0]];
    assign dr_s = mem_s[da_s[5:0]];

    always @(posedge clk) begin
        if (preload) begin
            for (int i = 0; i < DMEM_N; i++) begin
                mem_f[i] <= init_val(i);
                mem_s[i] <= init_val(i);
            end
        end else begin
            if (we_f) mem_f[da_f[5:0]] <= dw_f;
            if (we_s) mem_s[da_s[5:0]] <= dw_s;
        end
    end

    core2_pipe_cpu #(.FWD_EN(1'b1)) dut (
        .clk(clk), .rst(rst), .imem_addr(ia_f), .imem_rdata(ir_f),
        .dmem_addr(da_f), .dmem_wdata(dw_f), .dmem_we(we_f), .dmem_rdata(dr_f)
    );

    core2_pipe_cpu #(.FWD_EN(1'b0)) dut_stall (
        .clk(clk), .rst(rst), .imem_addr(ia_s), .imem_rdata(ir_s),
        .dmem_addr(da_s), .dmem_wdata(dw_s), .dmem_we(we_s), .dmem_rdata(dr_s)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    task automatic check(string tag, word_t act, word_t exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference: one instruction per step, own field slicing.
    task automatic run_ref();
        word_t rf [NREGS];
        word_t pc;
        for (int i = 0; i < NREGS; i++) rf[i] = '0;
        for (int i = 0; i < DMEM_N; i++) ref_mem[i] = init_val(i);
        pc = '0;
        for (int step = 0; step < 200 && pc != HALT_PC; step++) begin
            word_t w;
            int ra, rb, rc;
            w  = fetch(pc);
            ra = int'(w[29:25]);
            rb = int'(w[24:20]);
            rc = int'(w[19:15]);
            case (w[31:30])
                2'b00: begin rf[ra] = rf[rb] + rf[rc]; pc = pc + 1; end
                2'b01: pc = (rf[ra] == 0) ? rf[rb] : pc + 1;
                2'b10: begin rf[ra] = ref_mem[rf[rb][5:0]]; pc = pc + 1; end
                default: begin ref_mem[rf[rb][5:0]] = rf[ra]; pc = pc + 1; end
            endcase
        end
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int arr_f;
        int arr_s;
        int bad_f;
        int bad_s;
        arr_f = -1;
        arr_s = -1;
        run_ref();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset pc fwd", ia_f, 0);
        check("R1 reset pc stall", ia_s, 0);
        check("R1 no write in reset", word_t'(we_f | we_s), 0);
        rst = 1'b0;
        preload = 1'b0;

        for (int cyc = 1; cyc <= 200 && (arr_f < 0 || arr_s < 0); cyc++) begin
            @(posedge clk);
            @(negedge clk);
            if (cyc == 1) begin
                check("R2 sequential pc", ia_f, 1);
                check("R1 no write first cycle", word_t'(we_f), 0);
            end
            if (cyc == 2) begin
                check("R8 no stall on load-use", ia_f, 2);
                check("R9 stall holds pc", ia_s, 1);
            end
            if (cyc == 6) begin
                check("R5 store strobe", word_t'(we_f), 1);
                check("R5 store address", da_f, 40);
                check("R5 store data", dw_f, 30);
            end
            if (cyc == 11) check("R6 branch target", ia_f, 12);
            if (arr_f < 0 && ia_f == HALT_PC) arr_f = cyc;
            if (arr_s < 0 && ia_s == HALT_PC) arr_s = cyc;
        end

        check("R7 R11 fwd cycles to end", word_t'(arr_f), 18);
        check("R9 R10 stall cycles to end", word_t'(arr_s), 25);
        check("R11 forwarding faster", word_t'(arr_f < arr_s), 1);

        repeat (10) @(posedge clk);
        @(negedge clk);

        for (int k = 0; k < EXP_N; k++) begin
            check({exp_tag[k], " fwd"}, mem_f[EXP_ADDR[k]], word_t'(EXP_VAL[k]));
            check({exp_tag[k], " stall"}, mem_s[EXP_ADDR[k]], word_t'(EXP_VAL[k]));
        end

        bad_f = 0;
        bad_s = 0;
        for (int i = 0; i < DMEM_N; i++) begin
            if (mem_f[i] !== ref_mem[i]) bad_f++;
            if (mem_s[i] !== ref_mem[i]) bad_s++;
        end
        check("R11 fwd memory vs reference mismatches", word_t'(bad_f), 0);
        check("R11 stall memory vs reference mismatches", word_t'(bad_s), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule